// File: doc/BRIEF.md
# Interrupt pin capture and dispatcher

This block follows the levels of a bank of interrupt input pins and keeps one pending bit for each of them. It holds a per-pin redirection table. Each entry gives the pin's trigger style, a mask, the interrupt vector, a destination, a delivery mode, a destination mode and a polarity. Each rising request and each write to the table starts a scan. The scan walks the pins from the lowest number to the highest. For every unmasked pending pin it offers a delivery request on an output bus and waits for the receiver to accept or reject it.

Pins of the two trigger styles leave the pending state in different ways. Input 0 is folded onto input 2, the pin that carries the system timer. A rejected delivery marks the entry busy and is offered again on a later scan. A run of rejections raises a warning. For entries in the external-controller mode, the vector is not taken from the table: it is fetched from a separate acknowledge handshake with an external interrupt controller, and then delivered.

Top module: `ipd_dispatcher`

## Requirements
- R1: After synchronous reset no pin is pending, every delivery-status bit is clear, no request is offered, the warning is low, and every table entry is masked.
- R2: A level event on pin number 0 acts on pin 2. Events whose resulting pin number is not below the pin count (24) are ignored. An event whose level equals the stored level of that pin is ignored.
- R3: For a level-triggered pin, a high level sets the stored level and the pending bit, and a low level clears both.
- R4: For an edge-triggered pin, a rising level sets the stored level and the pending bit, and a falling level clears only the stored level.
- R5: A scan starts on a rising pin event or an in-range table write and visits pins in ascending order. A masked pending pin is skipped and its pending bit is kept. An unmasked one is offered with the fields of its entry, and the offer is held until it is answered. The configuration word is laid out as: vector [7:0], delivery mode [10:8], destination mode [11], polarity [12], trigger [13] (1 = level), mask [14], destination [22:15].
- R6: An entry whose delivery mode is 7 first raises the external acknowledge request. The vector returned with the acknowledge replaces the table vector in the offer.
- R7: An accepted offer clears the entry's delivery-status bit. It clears the pending bit of an edge-triggered pin only; a level-triggered pin stays pending.
- R8: A rejected offer sets the entry's delivery-status bit and keeps the pending bit, so the pin is offered again on a later scan.
- R9: Consecutive rejections are counted. The warning output is high while the count exceeds 5. Any accepted offer clears the count.
- R10: Only one offer is outstanding at a time. A rising event or a table write that arrives while a scan is running causes one further full pass from pin 0 after the current pass ends.
- R11: If an accepted offer clears a pin's pending bit in the same cycle as a new rising event on that pin, the pin stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Pin level event strobe |
| evt_pin | input | 5 | Pin number of the event |
| evt_level | input | 1 | New level of the pin |
| cfg_we | input | 1 | Table write strobe |
| cfg_pin | input | 5 | Table entry to write |
| cfg_data | input | 23 | Configuration word (layout in R5) |
| dlv_req | output | 1 | Delivery offer valid |
| dlv_vector | output | 8 | Offered vector |
| dlv_dest | output | 8 | Offered destination |
| dlv_mode | output | 3 | Offered delivery mode |
| dlv_dmode | output | 1 | Offered destination mode |
| dlv_pol | output | 1 | Offered polarity |
| dlv_trig | output | 1 | Offered trigger style |
| dlv_ok | input | 1 | Offer accepted (wins over reject) |
| dlv_rej | input | 1 | Offer rejected |
| eac_req | output | 1 | External acknowledge request |
| eac_ack | input | 1 | External acknowledge response |
| eac_vector | input | 8 | Vector returned with the acknowledge |
| pend_o | output | 24 | Pending bits per pin |
| dstat_o | output | 24 | Delivery-status bits per entry |
| warn_o | output | 1 | Repeated-rejection warning |

## Verification
Two actions can land on the same pending bit in one cycle: the clear that follows an accepted edge-triggered offer, and a fresh rising event on that same pin. The bench holds an offer open and drops the pin low. It then drives the accept and a new rising event at the same clock edge. The pin must still be pending afterwards, and the rising event must cause the pin to be offered again. A second overlap is a rising event that arrives while an offer is waiting. It is judged by the later pin being delivered only through the extra pass.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;
    localparam int ENT_W  = DEST_W + 4 + MODE_W + VEC_W;

    localparam logic [MODE_W-1:0] MODE_EXT = 3'd7;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;   // 1 = level
        logic              pol;
        logic              dmode;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vec;
    } redir_t;

    localparam redir_t REDIR_RST = '{dest: '0, mask: 1'b1, trig: 1'b0,
                                     pol: 1'b0, dmode: 1'b0, mode: '0, vec: '0};

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_STEP,
        SC_FETCH,
        SC_OFFER
    } scan_e;

    function automatic logic needs_fetch(redir_t e);
        return e.mode == MODE_EXT;
    endfunction

endpackage

// File: rtl/ipd_pin_capture.sv
module ipd_pin_capture
    import ipd_pkg::*;
#(
    parameter int NPINS   = 24,
    parameter int TMR_SRC = 0,
    parameter int TMR_DST = 2,
    localparam int PW     = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [PW-1:0]    evt_pin,
    input  logic             evt_level,
    input  logic [NPINS-1:0] trig_vec,
    input  logic             clr_en,
    input  logic [PW-1:0]    clr_idx,
    output logic [NPINS-1:0] pend,
    output logic             kick
);

    logic [PW-1:0]    eff_pin;
    logic             in_rng;
    logic             acts;
    logic [NPINS-1:0] lvl_q, pend_q, lvl_n, pend_n;

    always_comb begin
        eff_pin = (evt_pin == PW'(TMR_SRC)) ? PW'(TMR_DST) : evt_pin;
        in_rng  = ({1'b0, eff_pin} < (PW+1)'(NPINS));
        acts    = evt_valid && in_rng && (evt_level != lvl_q[eff_pin]);
        lvl_n   = lvl_q;
        pend_n  = pend_q;
        // the scan's clear is applied first so that a new event wins
        if (clr_en)
            pend_n[clr_idx] = 1'b0;
        if (acts) begin
            lvl_n[eff_pin] = evt_level;
            if (evt_level)
                pend_n[eff_pin] = 1'b1;
            else if (trig_vec[eff_pin])
                pend_n[eff_pin] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= lvl_n;
            pend_q <= pend_n;
        end
    end

    assign pend = pend_q;
    assign kick = acts && evt_level;

    a_r2_timer_remap: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_pin == PW'(TMR_SRC) && evt_level && !lvl_q[TMR_DST])
        |=> pend_q[TMR_DST]);

    a_r2_out_of_range_ignored: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !in_rng && !clr_en) |=> $stable(pend_q));

    a_r3_level_low_clears: assert property (@(posedge clk) disable iff (rst)
        (acts && !evt_level && trig_vec[eff_pin]) |=> !pend_q[$past(eff_pin)]);

    a_r4_edge_fall_keeps: assert property (@(posedge clk) disable iff (rst)
        (acts && !evt_level && !trig_vec[eff_pin] && pend_q[eff_pin]
         && !(clr_en && clr_idx == eff_pin)) |=> pend_q[$past(eff_pin)]);

    a_r11_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_en && acts && evt_level && clr_idx == eff_pin) |=> pend_q[$past(eff_pin)]);

endmodule

// File: rtl/ipd_redir_table.sv
module ipd_redir_table
    import ipd_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PW   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PW-1:0]    wr_idx,
    input  redir_t           wr_data,
    input  logic [PW-1:0]    rd_idx,
    output redir_t           rd_entry,
    output logic [NPINS-1:0] trig_vec,
    input  logic             st_set,
    input  logic             st_clr,
    input  logic [PW-1:0]    st_idx,
    output logic [NPINS-1:0] dstat,
    output logic             wr_kick
);

    redir_t           tbl_q [NPINS];
    logic [NPINS-1:0] stat_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[g] <= REDIR_RST;
            else if (we && wr_idx == PW'(g))
                tbl_q[g] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                stat_q[g] <= 1'b0;
            else if (st_set && st_idx == PW'(g))
                stat_q[g] <= 1'b1;
            else if (st_clr && st_idx == PW'(g))
                stat_q[g] <= 1'b0;
        end

        assign trig_vec[g] = tbl_q[g].trig;
    end

    always_comb begin
        rd_entry = REDIR_RST;
        for (int i = 0; i < NPINS; i++)
            if (rd_idx == PW'(i))
                rd_entry = tbl_q[i];
    end

    assign dstat   = stat_q;
    assign wr_kick = we && ({1'b0, wr_idx} < (PW+1)'(NPINS));

    a_r8_set_clear_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(st_set && st_clr));

endmodule

// File: rtl/ipd_scan_fsm.sv
module ipd_scan_fsm
    import ipd_pkg::*;
#(
    parameter int NPINS       = 24,
    parameter int STUCK_LIMIT = 5,
    localparam int PW         = $clog2(NPINS),
    localparam int CW         = $clog2(STUCK_LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [NPINS-1:0]  pend,
    input  redir_t            rd_entry,
    output logic [PW-1:0]     rd_idx,
    output logic              dlv_req,
    output redir_t            dlv_ent,
    input  logic              dlv_ok,
    input  logic              dlv_rej,
    output logic              eac_req,
    input  logic              eac_ack,
    input  logic [VEC_W-1:0]  eac_vector,
    output logic              clr_en,
    output logic              st_set,
    output logic              st_clr,
    output logic              warn
);

    localparam logic [PW-1:0] LAST = PW'(NPINS - 1);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    scan_e         state_q, state_n;
    logic [PW-1:0] idx_q, idx_n;
    logic          rescan_q, rescan_n;
    redir_t        cur_q, cur_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          advance;

    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        rescan_n = rescan_q | kick;
        cur_n    = cur_q;
        cnt_n    = cnt_q;
        clr_en   = 1'b0;
        st_set   = 1'b0;
        st_clr   = 1'b0;
        advance  = 1'b0;

        unique case (state_q)
            SC_IDLE: begin
                rescan_n = 1'b0;
                if (kick) begin
                    state_n = SC_STEP;
                    idx_n   = '0;
                end
            end
            SC_STEP: begin
                if (pend[idx_q] && !rd_entry.mask) begin
                    cur_n   = rd_entry;
                    state_n = needs_fetch(rd_entry) ? SC_FETCH : SC_OFFER;
                end else begin
                    advance = 1'b1;
                end
            end
            SC_FETCH: begin
                if (eac_ack) begin
                    cur_n.vec = eac_vector;
                    state_n   = SC_OFFER;
                end
            end
            SC_OFFER: begin
                if (dlv_ok) begin
                    clr_en  = !cur_q.trig;
                    st_clr  = 1'b1;
                    cnt_n   = '0;
                    advance = 1'b1;
                end else if (dlv_rej) begin
                    st_set  = 1'b1;
                    if (cnt_q != CMAX)
                        cnt_n = cnt_q + 1'b1;
                    advance = 1'b1;
                end
            end
            default: state_n = SC_IDLE;
        endcase

        if (advance) begin
            if (idx_q == LAST) begin
                idx_n    = '0;
                rescan_n = 1'b0;
                state_n  = (rescan_q || kick) ? SC_STEP : SC_IDLE;
            end else begin
                idx_n   = idx_q + 1'b1;
                state_n = SC_STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SC_IDLE;
            idx_q    <= '0;
            rescan_q <= 1'b0;
            cur_q    <= REDIR_RST;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_n;
            idx_q    <= idx_n;
            rescan_q <= rescan_n;
            cur_q    <= cur_n;
            cnt_q    <= cnt_n;
        end
    end

    assign rd_idx  = idx_q;
    assign dlv_req = (state_q == SC_OFFER);
    assign eac_req = (state_q == SC_FETCH);
    assign dlv_ent = cur_q;
    assign warn    = (cnt_q > CW'(STUCK_LIMIT));

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dlv_req, eac_req}));

    a_r5_offer_held: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && !dlv_ok && !dlv_rej) |=> (dlv_req && $stable(dlv_ent)));

    a_r6_fetch_leads_offer: assert property (@(posedge clk) disable iff (rst)
        (eac_req && eac_ack) |=> (dlv_req && dlv_ent.vec == $past(eac_vector)));

    a_r9_accept_drops_warning: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_ok) |=> !warn);

endmodule

// File: rtl/ipd_dispatcher.sv
module ipd_dispatcher
    import ipd_pkg::*;
#(
    parameter int NPINS       = 24,
    parameter int STUCK_LIMIT = 5,
    localparam int PW         = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [PW-1:0]     evt_pin,
    input  logic              evt_level,
    input  logic              cfg_we,
    input  logic [PW-1:0]     cfg_pin,
    input  logic [ENT_W-1:0]  cfg_data,
    output logic              dlv_req,
    output logic [VEC_W-1:0]  dlv_vector,
    output logic [DEST_W-1:0] dlv_dest,
    output logic [MODE_W-1:0] dlv_mode,
    output logic              dlv_dmode,
    output logic              dlv_pol,
    output logic              dlv_trig,
    input  logic              dlv_ok,
    input  logic              dlv_rej,
    output logic              eac_req,
    input  logic              eac_ack,
    input  logic [VEC_W-1:0]  eac_vector,
    output logic [NPINS-1:0]  pend_o,
    output logic [NPINS-1:0]  dstat_o,
    output logic              warn_o
);

    logic [NPINS-1:0] trig_vec;
    logic [PW-1:0]    scan_idx;
    redir_t           scan_ent;
    redir_t           offer_ent;
    logic             pin_kick, cfg_kick;
    logic             clr_en, st_set, st_clr;

    ipd_pin_capture #(.NPINS(NPINS)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_pin   (evt_pin),
        .evt_level (evt_level),
        .trig_vec  (trig_vec),
        .clr_en    (clr_en),
        .clr_idx   (scan_idx),
        .pend      (pend_o),
        .kick      (pin_kick)
    );

    ipd_redir_table #(.NPINS(NPINS)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wr_idx   (cfg_pin),
        .wr_data  (redir_t'(cfg_data)),
        .rd_idx   (scan_idx),
        .rd_entry (scan_ent),
        .trig_vec (trig_vec),
        .st_set   (st_set),
        .st_clr   (st_clr),
        .st_idx   (scan_idx),
        .dstat    (dstat_o),
        .wr_kick  (cfg_kick)
    );

    ipd_scan_fsm #(.NPINS(NPINS), .STUCK_LIMIT(STUCK_LIMIT)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kick       (pin_kick | cfg_kick),
        .pend       (pend_o),
        .rd_entry   (scan_ent),
        .rd_idx     (scan_idx),
        .dlv_req    (dlv_req),
        .dlv_ent    (offer_ent),
        .dlv_ok     (dlv_ok),
        .dlv_rej    (dlv_rej),
        .eac_req    (eac_req),
        .eac_ack    (eac_ack),
        .eac_vector (eac_vector),
        .clr_en     (clr_en),
        .st_set     (st_set),
        .st_clr     (st_clr),
        .warn       (warn_o)
    );

    assign dlv_vector = offer_ent.vec;
    assign dlv_dest   = offer_ent.dest;
    assign dlv_mode   = offer_ent.mode;
    assign dlv_dmode  = offer_ent.dmode;
    assign dlv_pol    = offer_ent.pol;
    assign dlv_trig   = offer_ent.trig;

    a_r7_accept_clears_status: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_ok) |=> !dstat_o[$past(scan_idx)]);

    a_r8_reject_marks_status: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_rej && !dlv_ok) |=> (dstat_o[$past(scan_idx)] && pend_o[$past(scan_idx)]));

endmodule

// File: tb/tb_ipd_dispatcher.sv
`timescale 1ns/1ps
module tb_ipd_dispatcher;

    localparam int NP = 24;
    localparam int PW = 5;
    localparam int WDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_pin = '0;
    logic        evt_level = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_pin = '0;
    logic [22:0] cfg_data = '0;
    logic        dlv_req;
    logic [7:0]  dlv_vector, dlv_dest;
    logic [2:0]  dlv_mode;
    logic        dlv_dmode, dlv_pol, dlv_trig;
    logic        dlv_ok = 1'b0, dlv_rej = 1'b0;
    logic        eac_req;
    logic        eac_ack = 1'b0;
    logic [7:0]  eac_vector = 8'h00;
    logic [NP-1:0] pend_o, dstat_o;
    logic        warn_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int resp = 0;   // 0 accept, 1 reject, 2 hold

    always #4 clk = ~clk;

    ipd_dispatcher dut (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_level(evt_level),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_data(cfg_data),
        .dlv_req(dlv_req), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_mode(dlv_mode), .dlv_dmode(dlv_dmode), .dlv_pol(dlv_pol),
        .dlv_trig(dlv_trig), .dlv_ok(dlv_ok), .dlv_rej(dlv_rej),
        .eac_req(eac_req), .eac_ack(eac_ack), .eac_vector(eac_vector),
        .pend_o(pend_o), .dstat_o(dstat_o), .warn_o(warn_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [22:0]   m_tbl [NP];
    logic [NP-1:0] m_pend, m_lvl, m_stat;
    logic [22:0]   m_cur;
    int            m_st, m_idx, m_cnt;
    bit            m_rescan;
    int            t_p, t_clr;
    bit            t_act, t_kick, t_adv;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) m_tbl[i] = 23'h004000;
            m_pend = '0; m_lvl = '0; m_stat = '0; m_cur = 23'h004000;
            m_st = 0; m_idx = 0; m_cnt = 0; m_rescan = 0;
        end else begin
            t_p   = (evt_pin == 0) ? 2 : int'(evt_pin);
            t_act = evt_valid && (t_p < NP) && (evt_level != m_lvl[t_p]);
            t_kick = (t_act && evt_level) || (cfg_we && int'(cfg_pin) < NP);
            t_clr = -1;
            t_adv = 0;
            case (m_st)
                0: if (t_kick) begin m_st = 1; m_idx = 0; m_rescan = 0; end
                1: begin
                    if (m_pend[m_idx] && !m_tbl[m_idx][14]) begin
                        m_cur = m_tbl[m_idx];
                        m_st = (m_tbl[m_idx][10:8] == 3'd7) ? 2 : 3;
                        m_rescan = m_rescan || t_kick;
                    end else t_adv = 1;
                end
                2: begin
                    m_rescan = m_rescan || t_kick;
                    if (eac_ack) begin m_cur[7:0] = eac_vector; m_st = 3; end
                end
                default: begin
                    m_rescan = m_rescan || t_kick;
                    if (dlv_ok) begin
                        if (!m_cur[13]) t_clr = m_idx;
                        m_stat[m_idx] = 1'b0; m_cnt = 0; t_adv = 1;
                    end else if (dlv_rej) begin
                        m_stat[m_idx] = 1'b1;
                        if (m_cnt < 7) m_cnt++;
                        t_adv = 1;
                    end
                end
            endcase
            if (t_adv) begin
                if (m_idx == NP - 1) begin
                    m_st = (m_rescan || t_kick) ? 1 : 0;
                    m_idx = 0; m_rescan = 0;
                end else begin
                    m_st = 1; m_idx++; m_rescan = m_rescan || t_kick;
                end
            end
            if (t_clr >= 0) m_pend[t_clr] = 1'b0;
            if (t_act) begin
                m_lvl[t_p] = evt_level;
                if (evt_level) m_pend[t_p] = 1'b1;
                else if (m_tbl[t_p][13]) m_pend[t_p] = 1'b0;
            end
            if (cfg_we && int'(cfg_pin) < NP) m_tbl[cfg_pin] = cfg_data;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [22:0] ent(logic [7:0] dest, logic msk, logic trg, logic pol,
                                        logic dm, logic [2:0] md, logic [7:0] vec);
        return {dest, msk, trg, pol, dm, md, vec};
    endfunction

    task automatic cyc();
        @(negedge clk);
        chk("R3", "pending bits vs model", 32'(pend_o), 32'(m_pend));
        chk("R8", "status bits vs model", 32'(dstat_o), 32'(m_stat));
        chk("R9", "warning vs model", 32'(warn_o), 32'(m_cnt > 5));
        chk("R10", "offer valid vs model", 32'(dlv_req), 32'(m_st == 3));
        chk("R6", "ext request vs model", 32'(eac_req), 32'(m_st == 2));
        if (m_st == 3)
            chk("R5", "offer fields vs model",
                {9'b0, dlv_dest, 1'b0, dlv_trig, dlv_pol, dlv_dmode, dlv_mode, dlv_vector},
                {9'b0, m_cur[22:15], 1'b0, m_cur[13:0]});
        evt_valid = 1'b0;
        cfg_we    = 1'b0;
        dlv_ok    = (resp == 0) && dlv_req;
        dlv_rej   = (resp == 1) && dlv_req;
        eac_ack   = eac_req;
    endtask

    task automatic pin(int p, logic l);
        cyc();
        evt_valid = 1'b1; evt_pin = 5'(p); evt_level = l;
    endtask

    task automatic cfg(int p, logic [22:0] d);
        cyc();
        cfg_we = 1'b1; cfg_pin = 5'(p); cfg_data = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_req(string tag);
        for (int i = 0; i < 200; i++) begin
            cyc();
            if (dlv_req) return;
        end
        chk(tag, "offer never appeared", 32'd0, 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            bad++;
            $display("FAIL R10 watchdog: cycles=%0d expected below %0d", cycles, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    logic [NP-1:0] snap;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        chk("R1", "pending after reset", 32'(pend_o), 32'd0);
        chk("R1", "status after reset", 32'(dstat_o), 32'd0);
        chk("R1", "offer after reset", 32'(dlv_req), 32'd0);
        chk("R1", "warning after reset", 32'(warn_o), 32'd0);

        // R1/R5: entries masked after reset, pending kept while skipped
        pin(3, 1);
        idle(40);
        chk("R1", "masked pin offered", 32'(dlv_req), 32'd0);
        chk("R5", "masked pin keeps pending", 32'(pend_o[3]), 32'd1);

        // R2/R5/R7: pin 0 folded onto pin 2, edge-triggered, accepted
        cfg(2, ent(8'h05, 0, 0, 0, 0, 3'd0, 8'h31));
        idle(30);
        pin(0, 1);
        wait_req("R2");
        chk("R2", "vector of remapped pin", 32'(dlv_vector), 32'h31);
        chk("R5", "destination field", 32'(dlv_dest), 32'h05);
        idle(30);
        chk("R7", "edge pending cleared on accept", 32'(pend_o[2]), 32'd0);
        chk("R7", "status cleared on accept", 32'(dstat_o[2]), 32'd0);
        pin(0, 0);
        idle(5);

        // R4: falling edge keeps pending
        cfg(6, ent(8'h00, 0, 0, 0, 0, 3'd0, 8'h36));
        idle(30);
        resp = 2;
        pin(6, 1);
        wait_req("R4");
        pin(6, 0);
        cyc();
        chk("R4", "fall keeps edge pending", 32'(pend_o[6]), 32'd1);
        resp = 0;
        idle(30);
        chk("R4", "edge pending after accept", 32'(pend_o[6]), 32'd0);

        // R2: out-of-range pin ignored
        snap = pend_o;
        pin(30, 1);
        idle(30);
        chk("R2", "out-of-range event", 32'(pend_o), 32'(snap));
        chk("R2", "out-of-range offer", 32'(dlv_req), 32'd0);

        // R3/R7: level-triggered pin
        cfg(5, ent(8'h0a, 0, 1, 1, 0, 3'd0, 8'h45));
        idle(30);
        pin(5, 1);
        wait_req("R3");
        chk("R5", "level vector", 32'(dlv_vector), 32'h45);
        chk("R5", "trigger and polarity", {30'd0, dlv_trig, dlv_pol}, 32'd3);
        idle(30);
        chk("R7", "level pending stays after accept", 32'(pend_o[5]), 32'd1);
        pin(5, 0);
        idle(30);
        chk("R3", "level low clears pending", 32'(pend_o[5]), 32'd0);

        // R6: vector fetched from external controller
        eac_vector = 8'h99;
        cfg(7, ent(8'h03, 0, 0, 0, 1, 3'd7, 8'h00));
        idle(30);
        pin(7, 1);
        wait_req("R6");
        chk("R6", "fetched vector", 32'(dlv_vector), 32'h99);
        chk("R6", "mode and destination mode", {28'd0, dlv_mode, dlv_dmode}, 32'hf);
        idle(30);

        // R8/R9: rejection, retry and warning
        cfg(9, ent(8'h01, 0, 0, 0, 0, 3'd0, 8'h59));
        idle(30);
        resp = 1;
        pin(9, 1);
        wait_req("R8");
        cyc();
        chk("R8", "status set on reject", 32'(dstat_o[9]), 32'd1);
        chk("R8", "pending kept on reject", 32'(pend_o[9]), 32'd1);
        for (int k = 2; k <= 6; k++) begin
            idle(30);
            cfg(9, ent(8'h01, 0, 0, 0, 0, 3'd0, 8'h59));
            wait_req("R8");
            cyc();
            if (k == 5) chk("R9", "warning after 5 rejects", 32'(warn_o), 32'd0);
            if (k == 6) chk("R9", "warning after 6 rejects", 32'(warn_o), 32'd1);
        end
        idle(30);
        resp = 0;
        cfg(9, ent(8'h01, 0, 0, 0, 0, 3'd0, 8'h59));
        wait_req("R9");
        cyc();
        chk("R9", "warning cleared by accept", 32'(warn_o), 32'd0);
        chk("R7", "status cleared by accept", 32'(dstat_o[9]), 32'd0);
        chk("R7", "pending cleared by accept", 32'(pend_o[9]), 32'd0);
        idle(30);

        // R10: event during an open offer causes another pass
        cfg(14, ent(8'h00, 0, 0, 0, 0, 3'd0, 8'h74));
        cfg(12, ent(8'h00, 0, 0, 0, 0, 3'd0, 8'h72));
        idle(30);
        resp = 2;
        pin(14, 1);
        wait_req("R10");
        chk("R10", "first offer", 32'(dlv_vector), 32'h74);
        pin(12, 1);
        resp = 0;
        cyc();
        cyc();
        wait_req("R10");
        chk("R10", "offer from extra pass", 32'(dlv_vector), 32'h72);
        idle(40);

        // R11: accept-clear and new rising edge in the same cycle
        cfg(16, ent(8'h00, 0, 0, 0, 0, 3'd0, 8'h86));
        idle(30);
        resp = 2;
        pin(16, 1);
        wait_req("R11");
        pin(16, 0);
        cyc();
        dlv_ok = 1'b1;
        evt_valid = 1'b1; evt_pin = 5'd16; evt_level = 1'b1;
        cyc();
        chk("R11", "pending kept by same-cycle edge", 32'(pend_o[16]), 32'd1);
        resp = 0;
        idle(60);
        chk("R11", "pin offered again then cleared", 32'(pend_o[16]), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule